// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM

This block is a synthesizable, cycle-accurate model of a synchronous static RAM. It can run bursts of four words and has a registered read path. An access starts at a rising clock edge when either of two start strobes is low and the three chip selects agree. One strobe is meant for a processor and the other for a memory controller. Each start latches a new external address. After that, the advance input steps a small beat counter. The beat counter rewrites only the low two address bits, in either linear or interleaved order. When advance is high, the counter holds.

Writes can cover the whole word or selected byte lanes. A start from the processor strobe is always a read. Its write decision is taken on the following edge. Read data leaves through an output register. A separate drive-enable output gates the output, as a tri-state pad would. The drive-enable falls one clock after a write or a deselect, and it also falls whenever the output-enable input is high. A sleep request pin is present but has no effect.

Top module: `burst_sram`

## Requirements
- R1: The device is selected only when `sel_a_n`=0, `sel_b_n`=0 and `sel_c`=1. A start strobe taken while the device is not selected performs no access and ends any burst in progress.
- R2: A low level on `proc_strobe_n` or `ctrl_strobe_n` starts a burst at `addr`. A start from `ctrl_strobe_n` alone honours the write controls sampled at that same edge.
- R3: A start in which `proc_strobe_n` is low is always a read, whatever the write controls. At the next edge (no strobe, `advance_n` high), the write controls decide between a read and a write of that same address.
- R4: A read registered at edge k drives its word on `dout` with `dout_en` high after edge k+1 (given `out_en_n`=0).
- R5: With `order_linear`=1, each edge with `advance_n`=0 and no strobe accesses low bits (start+n) mod 4 at beat n. The upper address bits stay fixed.
- R6: With `order_linear`=0, beat n uses low bits start XOR n. The order is latched at the start, so later changes of `order_linear` within the burst are ignored.
- R7: An edge with no strobe and `advance_n`=1 inside a burst re-accesses the current word. A read repeats that word, and a write overwrites it.
- R8: The fourth advance returns the burst to the start address.
- R9: Byte lane i is `din[8i+7:8i]`. `all_wr_n`=0 writes all lanes. Otherwise `lane_wr_en_n`=0 writes lane i where `lane_wr_n[i]`=0. With no lane selected, the access is a read.
- R10: `dout_en` is low while `out_en_n`=1. It is also low one clock after a write access, and one clock after an edge with no read access, including a deselect.
- R11: `sleep_req` has no effect on any output.
- R12: After reset, `dout_en` is low and no burst is active. Advance edges before the first start perform no access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | ADDR_W | External word address |
| proc_strobe_n | input | 1 | Processor start strobe, active low |
| ctrl_strobe_n | input | 1 | Controller start strobe, active low |
| advance_n | input | 1 | Burst advance, active low |
| all_wr_n | input | 1 | Whole-word write, active low |
| lane_wr_en_n | input | 1 | Enables per-lane write strobes, active low |
| lane_wr_n | input | DATA_W/LANE_W | Per-lane write strobes, active low |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b_n | input | 1 | Chip select, active low |
| sel_c | input | 1 | Chip select, active high |
| out_en_n | input | 1 | Output enable, active low |
| order_linear | input | 1 | Burst order: 1 linear, 0 interleaved |
| sleep_req | input | 1 | Sleep request, ignored |
| din | input | DATA_W | Write data |
| dout | output | DATA_W | Registered read data |
| dout_en | output | 1 | Drive enable for `dout` |

## Verification
The hardest case to reach is the processor-strobe start. The read it forces must be followed, on the next edge, by a write to the same word with advance held high. The stimulus asserts the whole-word write during the start edge, which must have no effect. It then repeats the write with new data on the following edge and reads the word back. Deselects in the middle of a burst and suspended write bursts, where a held beat is overwritten, are built the same way. A reference array predicts each output word.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;
   typedef enum logic [2:0] {
      CYC_IDLE,
      CYC_START_PROC,
      CYC_START_CTRL,
      CYC_CONT,
      CYC_DESEL
   } cyc_kind_e;
endpackage

// File: rtl/bsram_burst_ctr.sv
module bsram_burst_ctr #(
   parameter int ADDR_W = 8,
   parameter int BEAT_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              step,
   input  logic              order_lin,
   input  logic [ADDR_W-1:0] ext_addr,
   output logic [ADDR_W-1:0] acc_addr
);
   localparam int HI_W = ADDR_W - BEAT_W;

   logic [HI_W-1:0]   hi_q;
   logic [BEAT_W-1:0] lo_q;
   logic [BEAT_W-1:0] cnt_q;
   logic [BEAT_W-1:0] cnt_use;
   logic [BEAT_W-1:0] lo_acc;
   logic              lin_q;

   always_comb begin
      cnt_use  = step ? cnt_q + BEAT_W'(1) : cnt_q;
      lo_acc   = lin_q ? (lo_q + cnt_use) : (lo_q ^ cnt_use);
      acc_addr = start ? ext_addr : {hi_q, lo_acc};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_q  <= '0;
         lo_q  <= '0;
         cnt_q <= '0;
         lin_q <= 1'b1;
      end else if (start) begin
         hi_q  <= ext_addr[ADDR_W-1:BEAT_W];
         lo_q  <= ext_addr[BEAT_W-1:0];
         cnt_q <= '0;
         lin_q <= order_lin;
      end else if (step) begin
         cnt_q <= cnt_use;
      end
   end

   // R8: the last advance of a burst lands on the start address
   p_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !start && (cnt_q == '1)) |-> (acc_addr == {hi_q, lo_q}));
endmodule

// File: rtl/bsram_array.sv
module bsram_array #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32,
   parameter int LANE_W = 8
) (
   input  logic                       clk,
   input  logic [DATA_W/LANE_W-1:0]   we_lanes,
   input  logic [ADDR_W-1:0]          wr_addr,
   input  logic [DATA_W-1:0]          wdata,
   input  logic [ADDR_W-1:0]          rd_addr,
   output logic [DATA_W-1:0]          rdata
);
   localparam int LANES = DATA_W / LANE_W;
   localparam int DEPTH = 1 << ADDR_W;

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic [LANE_W-1:0] mem [DEPTH];
      always_ff @(posedge clk) begin
         if (we_lanes[i]) mem[wr_addr] <= wdata[i*LANE_W +: LANE_W];
      end
      assign rdata[i*LANE_W +: LANE_W] = mem[rd_addr];
   end
endmodule

// File: rtl/burst_sram.sv
module burst_sram
   import burst_sram_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32,
   parameter int LANE_W = 8,
   parameter int BEAT_W = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [ADDR_W-1:0]        addr,
   input  logic                     proc_strobe_n,
   input  logic                     ctrl_strobe_n,
   input  logic                     advance_n,
   input  logic                     all_wr_n,
   input  logic                     lane_wr_en_n,
   input  logic [DATA_W/LANE_W-1:0] lane_wr_n,
   input  logic                     sel_a_n,
   input  logic                     sel_b_n,
   input  logic                     sel_c,
   input  logic                     out_en_n,
   input  logic                     order_linear,
   input  logic                     sleep_req,
   input  logic [DATA_W-1:0]        din,
   output logic [DATA_W-1:0]        dout,
   output logic                     dout_en
);
   localparam int LANES = DATA_W / LANE_W;

   if (DATA_W % LANE_W != 0) begin : g_bad_lane
      $error("DATA_W must be a multiple of LANE_W");
   end
   if (BEAT_W < 1 || BEAT_W >= ADDR_W) begin : g_bad_beat
      $error("BEAT_W must be at least 1 and below ADDR_W");
   end

   logic             unused_sleep;
   assign unused_sleep = sleep_req;

   cyc_kind_e         kind;
   logic              selected, strobe, start, step, acc, acc_wr, acc_rd;
   logic              active_q, rd_pend_q, dvld_q;
   logic [LANES-1:0]  lane_req, wr_lanes;
   logic [ADDR_W-1:0] acc_addr, rd_addr_q, last_addr_q;
   logic [DATA_W-1:0] rdata, dout_q;

   assign selected = !sel_a_n && !sel_b_n && sel_c;
   assign strobe   = !proc_strobe_n || !ctrl_strobe_n;

   always_comb begin
      if (strobe && selected)      kind = proc_strobe_n ? CYC_START_CTRL : CYC_START_PROC;
      else if (strobe)             kind = CYC_DESEL;
      else if (active_q)           kind = CYC_CONT;
      else                         kind = CYC_IDLE;
   end

   assign start = (kind == CYC_START_PROC) || (kind == CYC_START_CTRL);
   assign step  = (kind == CYC_CONT) && !advance_n;
   assign acc   = start || (kind == CYC_CONT);

   for (genvar i = 0; i < LANES; i++) begin : g_lane_req
      assign lane_req[i] = !all_wr_n || (!lane_wr_en_n && !lane_wr_n[i]);
   end

   assign wr_lanes = ((kind == CYC_START_CTRL) || (kind == CYC_CONT)) ? lane_req : '0;
   assign acc_wr   = |wr_lanes;
   assign acc_rd   = acc && !acc_wr;

   bsram_burst_ctr #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_ctr (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .step      (step),
      .order_lin (order_linear),
      .ext_addr  (addr),
      .acc_addr  (acc_addr)
   );

   bsram_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANE_W(LANE_W)) u_mem (
      .clk      (clk),
      .we_lanes (wr_lanes),
      .wr_addr  (acc_addr),
      .wdata    (din),
      .rd_addr  (rd_addr_q),
      .rdata    (rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q    <= 1'b0;
         rd_pend_q   <= 1'b0;
         rd_addr_q   <= '0;
         last_addr_q <= '0;
         dvld_q      <= 1'b0;
         dout_q      <= '0;
      end else begin
         if (start)                   active_q <= 1'b1;
         else if (kind == CYC_DESEL)  active_q <= 1'b0;
         rd_pend_q <= acc_rd;
         if (acc_rd) rd_addr_q   <= acc_addr;
         if (acc)    last_addr_q <= acc_addr;
         dvld_q <= rd_pend_q;
         if (rd_pend_q) dout_q <= rdata;
      end
   end

   assign dout    = dout_q;
   assign dout_en = dvld_q && !out_en_n;

   // R4: a registered read reaches the output stage one clock later
   p_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
      acc_rd |=> ##1 dvld_q);
   // R10: no drive one clock after a write access
   p_wr_nodrive_r10: assert property (@(posedge clk) disable iff (!rst_n)
      acc_wr |=> ##1 !dout_en);
   // R1: a deselect strobe leaves nothing to drive
   p_desel_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe && !selected) |=> ##1 !dout_en);
   // R3: a processor-strobe start always queues a read
   p_proc_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !proc_strobe_n) |=> rd_pend_q);
   // R7: a held beat re-accesses the previous word
   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ((kind == CYC_CONT) && advance_n) |-> (acc_addr == last_addr_q));
   // R12: without an active burst, advance edges queue no read
   p_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (!active_q && !strobe) |=> !rd_pend_q);
endmodule

// File: tb/sim_burst_sram.sv
`timescale 1ns/1ps
module sim_burst_sram;
   localparam int AW = 8;
   localparam int DW = 32;
   localparam int LN = 4;

   typedef struct {
      bit          rd;
      logic [DW-1:0] data;
      string       tag;
   } item_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] addr = '0;
   logic          proc_n = 1'b1, ctrl_n = 1'b1, adv_n = 1'b1;
   logic          gw_n = 1'b1, bwe_n = 1'b1;
   logic [LN-1:0] bw_n = '1;
   logic          sa_n = 1'b0, sb_n = 1'b0, sc = 1'b1;
   logic          oe_n = 1'b0, lin = 1'b1, sleep = 1'b0;
   logic [DW-1:0] din = '0;
   logic [DW-1:0] dout;
   logic          dout_en;

   int errors = 0;
   int checks = 0;
   item_t q[$];

   logic [DW-1:0] ref_mem [1<<AW];
   bit            m_active = 0;
   logic [AW-1:0] m_base;
   logic [1:0]    m_cnt;
   bit            m_lin;

   always #4 clk = ~clk;

   burst_sram u0 (
      .clk(clk), .rst_n(rst_n), .addr(addr),
      .proc_strobe_n(proc_n), .ctrl_strobe_n(ctrl_n), .advance_n(adv_n),
      .all_wr_n(gw_n), .lane_wr_en_n(bwe_n), .lane_wr_n(bw_n),
      .sel_a_n(sa_n), .sel_b_n(sb_n), .sel_c(sc), .out_en_n(oe_n),
      .order_linear(lin), .sleep_req(sleep), .din(din),
      .dout(dout), .dout_en(dout_en)
   );

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   // reference model for one edge, then push expected output item
   task automatic tick(input string tag);
      item_t it;
      bit sel, strb, acc, wr;
      logic [LN-1:0] lanes;
      logic [AW-1:0] a;
      logic [1:0] lo;
      @(posedge clk);
      #1;
      sel  = !sa_n && !sb_n && sc;
      strb = !proc_n || !ctrl_n;
      for (int i = 0; i < LN; i++) lanes[i] = !gw_n || (!bwe_n && !bw_n[i]);
      acc = 0; wr = 0; a = '0;
      if (strb && sel) begin
         m_active = 1; m_base = addr; m_cnt = 0; m_lin = lin;
         acc = 1; a = addr;
         wr = proc_n && (|lanes);
      end else if (strb) begin
         m_active = 0;
      end else if (m_active) begin
         if (!adv_n) m_cnt = m_cnt + 2'd1;
         lo = m_lin ? (m_base[1:0] + m_cnt) : (m_base[1:0] ^ m_cnt);
         a = {m_base[AW-1:2], lo};
         acc = 1; wr = |lanes;
      end
      if (acc && wr) begin
         for (int i = 0; i < LN; i++)
            if (lanes[i]) ref_mem[a][i*8 +: 8] = din[i*8 +: 8];
      end
      it.rd   = acc && !wr;
      it.data = it.rd ? ref_mem[a] : '0;
      it.tag  = tag;
      q.push_back(it);
      @(negedge clk);
      #1;
   endtask

   // monitor: item pushed at edge k is checked after edge k+1
   initial begin
      forever begin
         @(negedge clk);
         if (q.size() >= 2) begin
            item_t it;
            bit exp_en;
            it = q.pop_front();
            exp_en = it.rd && !oe_n;
            checks++;
            if (dout_en !== exp_en) begin
               errors++;
               $display("FAIL %s dout_en actual=%0b expected=%0b", it.tag, dout_en, exp_en);
            end
            if (exp_en) begin
               checks++;
               if (dout !== it.data) begin
                  errors++;
                  $display("FAIL %s dout actual=%h expected=%h", it.tag, dout, it.data);
               end
            end
         end
      end
   end

   initial begin
      #(8 * 200000);
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
   end

   task automatic wr1(input logic [AW-1:0] a, input logic [DW-1:0] d, input string tag);
      ctrl_n = 0; gw_n = 0; addr = a; din = d;
      tick(tag);
      ctrl_n = 1; gw_n = 1;
   endtask

   task automatic burst_rd(input logic [AW-1:0] a, input bit l, input int beats, input string tag);
      ctrl_n = 0; addr = a; lin = l;
      tick(tag);
      ctrl_n = 1; adv_n = 0;
      for (int b = 1; b < beats; b++) tick(tag);
      adv_n = 1;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1;
      #1;
      checks++;
      if (dout_en !== 1'b0) begin
         errors++;
         $display("FAIL R12 dout_en actual=%0b expected=0", dout_en);
      end
      // R12: advance before any start does nothing
      adv_n = 0;
      tick("R12");
      tick("R12");
      adv_n = 1;

      // R2 R9: whole-word writes from the controller strobe
      for (int i = 0; i < 32; i++)
         wr1(AW'(i), {8'hC3, 8'(i), 8'(~i), 8'(i * 7)}, "R2 R9");

      // R5 R8 R4: linear bursts from each offset, one extra beat wraps
      for (int s = 0; s < 4; s++) burst_rd(AW'(8 + s), 1'b1, 5, "R5 R8 R4");
      // R6 R8: interleaved bursts from each offset
      for (int s = 0; s < 4; s++) burst_rd(AW'(16 + s), 1'b0, 5, "R6 R8");

      // R6: order change inside a burst is ignored
      ctrl_n = 0; addr = 8'd21; lin = 0;
      tick("R6");
      ctrl_n = 1; adv_n = 0; lin = 1;
      repeat (3) tick("R6");
      adv_n = 1;

      // R7: suspended read repeats the word
      ctrl_n = 0; addr = 8'd4;
      tick("R7");
      ctrl_n = 1; adv_n = 0; tick("R7");
      adv_n = 1; tick("R7"); tick("R7");
      adv_n = 0; tick("R7");
      adv_n = 1;

      // R7: suspended write burst overwrites the held word
      ctrl_n = 0; gw_n = 0; addr = 8'd12; din = 32'h1111_0001;
      tick("R7");
      ctrl_n = 1; adv_n = 0; din = 32'h2222_0002; tick("R7");
      adv_n = 1; din = 32'h3333_0003; tick("R7");
      adv_n = 0; din = 32'h4444_0004; tick("R7");
      gw_n = 1; adv_n = 1;
      burst_rd(8'd12, 1'b1, 4, "R7");

      // R3: processor start ignores write, next edge writes same word
      proc_n = 0; gw_n = 0; addr = 8'd24; din = 32'hDEAD_0024;
      tick("R3");
      proc_n = 1; adv_n = 1; din = 32'hBEEF_0024;
      tick("R3");
      gw_n = 1;
      burst_rd(8'd24, 1'b1, 1, "R3");

      // R9: lane writes, then lane enable with no lane is a read
      ctrl_n = 0; bwe_n = 0; bw_n = 4'b1010; addr = 8'd25; din = 32'hFFFF_FFFF;
      tick("R9");
      bw_n = 4'hF; addr = 8'd26;
      tick("R9");
      ctrl_n = 1; bwe_n = 1;
      burst_rd(8'd25, 1'b1, 1, "R9");

      // R1 R10: deselect strobes
      ctrl_n = 0; sc = 0; addr = 8'd3;
      tick("R1 R10");
      sc = 1; sa_n = 1;
      tick("R1 R10");
      sa_n = 0; sb_n = 1;
      tick("R1 R10");
      sb_n = 0; ctrl_n = 1;
      // deselect mid-burst ends it
      ctrl_n = 0; addr = 8'd5;
      tick("R1");
      ctrl_n = 1; adv_n = 0; tick("R1");
      ctrl_n = 0; sc = 0; adv_n = 1; tick("R1 R10");
      ctrl_n = 1; sc = 1; adv_n = 0; tick("R1");
      tick("R1");
      adv_n = 1;

      // R10: output enable gating
      ctrl_n = 0; addr = 8'd10;
      tick("R10");
      ctrl_n = 1; adv_n = 0; tick("R10");
      oe_n = 1; tick("R10");
      oe_n = 0; tick("R10");
      adv_n = 1;

      // R11: sleep request has no effect
      sleep = 1;
      burst_rd(8'd18, 1'b0, 4, "R11");
      wr1(8'd30, 32'h5A5A_0030, "R11");
      burst_rd(8'd30, 1'b1, 1, "R11");
      sleep = 0;

      tick("drain");
      tick("drain");
      @(negedge clk);
      summary();
      $finish;
   end
endmodule